// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block divides the module clock into time quanta and walks each nominal CAN bit through three phases: a one-quantum synchronisation phase, a first timing phase and a second timing phase. It raises a sample strobe on the quantum boundary that closes the first phase. It raises a transmit strobe on the boundary that closes the bit, where the transmitter launches its next bit. It also delivers the bus value taken at the sample point. That value is a single sample, or the majority of three samples when triple sampling is selected.

The block keeps its phase aligned with the bus. Edges are watched only at quantum boundaries. An edge is a boundary where the bus reads dominant (0) after reading recessive (1) at the boundary before. While the frame-start input is high, any such edge restarts the bit (hard synchronisation). Otherwise the edge stretches the first phase or trims the second, by no more than the jump width, and at most once per bit.

A 24-bit timing word is captured only while the hold input is high; the hold models the controller's reset mode and keeps all timing state idle. Frame decoding, bit stuffing and driving the bus are handled elsewhere.

Top module: `can_bittime_gen`

## Requirements
- R1: Timing word bits 9:0 hold the prescaler minus one; with prescaler value P, tq_tick pulses for one cycle once every P clock cycles while running (P = 1 gives a pulse every cycle).
- R2: Bits 19:16 hold phase-1 length minus one (T1 quanta, 1..16) and bits 22:20 hold phase-2 length minus one (T2 quanta, 1..8); with no edges, counting tq_tick pulses from release of hold, sample_strb coincides with pulse 1+T1 and tx_strb with pulse 1+T1+T2, repeating every 1+T1+T2 pulses; the two strobes only ever coincide with a tq_tick pulse.
- R3: With bit 23 clear, rx_bit updates together with sample_strb to the bus value read at the quantum boundary that ends phase 1, and holds otherwise.
- R4: With bit 23 set, rx_bit takes the majority of the bus values read at the sample boundary and at the two boundaries before it.
- R5: An edge in phase 1, on its k-th quantum (k counted from 1), lengthens phase 1 by min(k, J) quanta, where bits 15:14 hold the jump width J minus one (J = 1..4).
- R6: An edge in phase 2 with r quanta of the nominal phase 2 still to follow shortens phase 2 by min(r, J) quanta; when r is at most J the bit ends on the edge quantum.
- R7: At most one resynchronisation is applied per bit; an edge that falls on the synchronisation quantum changes nothing.
- R8: With hs_en high, an edge in any phase makes its quantum the synchronisation quantum of a new bit, so the next sample strobe comes T1 pulses later and no transmit strobe is given for the cut-short bit.
- R9: While cfg_hold is high, tq_tick, sample_strb and tx_strb stay low, rx_bit reads 1 and cfg_word is captured; changes to cfg_word while cfg_hold is low have no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hold | input | 1 | High: idle and capture the timing word |
| cfg_word | input | 24 | Packed timing word (prescaler, jump width, phase lengths, triple-sample flag) |
| hs_en | input | 1 | High while the bus is idle: edges cause hard synchronisation |
| rx_in | input | 1 | Bus level, 1 recessive, 0 dominant |
| tq_tick | output | 1 | One-cycle pulse at every time-quantum boundary |
| sample_strb | output | 1 | Sample-point pulse |
| tx_strb | output | 1 | End-of-bit (transmit point) pulse |
| rx_bit | output | 1 | Bus value taken at the last sample point |

## Verification
The bench builds the block with its default field widths (10-bit prescaler, 2-bit jump width, 4-bit and 3-bit phase lengths) and a three-sample majority window. Under those widths it runs prescaler values 1, 3 and 64, a 5/3 quantum phase split, and jump widths 1, 2 and 4. That is enough to reach the jump-width limit, the one-resync-per-bit rule, and a phase-2 edge that ends the bit on the edge quantum. Triple sampling is run with bus patterns for which the majority and the single sample differ.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  localparam int unsigned BRP_W      = 10;
  localparam int unsigned SJW_W      = 2;
  localparam int unsigned TS1_W      = 4;
  localparam int unsigned TS2_W      = 3;

  localparam int unsigned BRP_LSB    = 0;
  localparam int unsigned SJW_LSB    = 14;
  localparam int unsigned TS1_LSB    = 16;
  localparam int unsigned TS2_LSB    = 20;
  localparam int unsigned TRIPLE_POS = 23;
  localparam int unsigned CFG_W      = 24;

  // phase 1 can grow by the jump width, so leave headroom above TS1_W
  localparam int unsigned QCNT_W     = TS1_W + 2;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;

  typedef struct packed {
    logic             triple;
    logic [TS2_W-1:0] ph2_m1;
    logic [TS1_W-1:0] ph1_m1;
    logic [SJW_W-1:0] sjw_m1;
    logic [BRP_W-1:0] brp_m1;
  } bt_cfg_t;

  function automatic bt_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    bt_cfg_t c;
    c.brp_m1 = w[BRP_LSB +: BRP_W];
    c.sjw_m1 = w[SJW_LSB +: SJW_W];
    c.ph1_m1 = w[TS1_LSB +: TS1_W];
    c.ph2_m1 = w[TS2_LSB +: TS2_W];
    c.triple = w[TRIPLE_POS];
    return c;
  endfunction

endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int unsigned W = can_bt_pkg::BRP_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] brp_m1,
  output logic         tick_now,
  output logic         tick_q
);
  logic [W-1:0] div_cnt;

  assign tick_now = run && (div_cnt == brp_m1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= tick_now;
      if (tick_now) div_cnt <= '0;
      else          div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic rx,
  output logic fall_now
);
  logic rx_prev;

  // edge = recessive at previous quantum boundary, dominant at this one
  assign fall_now = tick && rx_prev && !rx;

  always_ff @(posedge clk) begin
    if (rst || !run)  rx_prev <= 1'b1;
    else if (tick)    rx_prev <= rx;
  end
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler #(
  parameter int unsigned WIN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic sample_now,
  input  logic rx,
  input  logic triple,
  output logic bit_q
);
  localparam int unsigned HW = WIN - 1;

  logic [HW-1:0]  hist;
  logic [WIN-1:0] window;
  logic           vote;

  assign window = {hist, rx};
  assign vote   = ($countones(window) > (WIN / 2));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hist  <= '1;
      bit_q <= 1'b1;
    end else begin
      if (tick)       hist  <= window[HW-1:0];
      if (sample_now) bit_q <= triple ? vote : rx;
    end
  end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int unsigned P1_W = TS1_W,
  parameter int unsigned P2_W = TS2_W,
  parameter int unsigned J_W  = SJW_W,
  parameter int unsigned CW   = QCNT_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            tick,
  input  logic            fall,
  input  logic            hs_en,
  input  logic [P1_W-1:0] ph1_m1,
  input  logic [P2_W-1:0] ph2_m1,
  input  logic [J_W-1:0]  sjw_m1,
  output logic            sample_now,
  output logic            sample_q,
  output logic            tx_q
);
  localparam int unsigned LW = CW + 1;

  seg_e          seg;
  logic [LW-1:0] qcnt, ph1_add, ph2_sub;
  logic          rs_used;

  logic [LW-1:0] ph1_len, ph2_len, jw, qcnt_p1;
  logic [LW-1:0] add_new, sub_new, rem2, ph1_lim, ph2_lim;
  logic          hard, resync, ph1_end, ph2_end;

  always_comb begin
    ph1_len = LW'(ph1_m1) + LW'(1);
    ph2_len = LW'(ph2_m1) + LW'(1);
    jw      = LW'(sjw_m1) + LW'(1);
    qcnt_p1 = qcnt + LW'(1);
    hard    = fall && hs_en;
    resync  = fall && !hs_en && !rs_used;
    add_new = (qcnt_p1 < jw) ? qcnt_p1 : jw;
    rem2    = (ph2_len > qcnt_p1) ? (ph2_len - qcnt_p1) : '0;
    sub_new = (rem2 < jw) ? rem2 : jw;
    ph1_lim = ph1_len + ((resync && seg == SEG_PH1) ? add_new : ph1_add);
    ph2_lim = ph2_len - ((resync && seg == SEG_PH2) ? sub_new : ph2_sub);
    ph1_end = tick && !hard && (seg == SEG_PH1) && (qcnt_p1 >= ph1_lim);
    ph2_end = tick && !hard && (seg == SEG_PH2) && (qcnt_p1 >= ph2_lim);
  end

  assign sample_now = ph1_end;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      seg      <= SEG_SYNC;
      qcnt     <= '0;
      ph1_add  <= '0;
      ph2_sub  <= '0;
      rs_used  <= 1'b0;
      sample_q <= 1'b0;
      tx_q     <= 1'b0;
    end else begin
      sample_q <= ph1_end;
      tx_q     <= ph2_end;
      if (tick) begin
        if (hard) begin
          seg     <= SEG_PH1;
          qcnt    <= '0;
          ph1_add <= '0;
          ph2_sub <= '0;
          rs_used <= 1'b0;
        end else begin
          case (seg)
            SEG_SYNC: begin
              seg  <= SEG_PH1;
              qcnt <= '0;
            end
            SEG_PH1: begin
              if (resync) begin
                ph1_add <= add_new;
                rs_used <= 1'b1;
              end
              if (ph1_end) begin
                seg  <= SEG_PH2;
                qcnt <= '0;
              end else begin
                qcnt <= qcnt_p1;
              end
            end
            SEG_PH2: begin
              if (resync) begin
                ph2_sub <= sub_new;
                rs_used <= 1'b1;
              end
              if (ph2_end) begin
                seg     <= SEG_SYNC;
                qcnt    <= '0;
                ph1_add <= '0;
                ph2_sub <= '0;
                rs_used <= 1'b0;
              end else begin
                qcnt <= qcnt_p1;
              end
            end
            default: begin
              seg  <= SEG_SYNC;
              qcnt <= '0;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/can_bittime_gen.sv
module can_bittime_gen
  import can_bt_pkg::*;
#(
  parameter int unsigned VOTE_WIN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_hold,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             hs_en,
  input  logic             rx_in,
  output logic             tq_tick,
  output logic             sample_strb,
  output logic             tx_strb,
  output logic             rx_bit
);
  bt_cfg_t          cfg_q;
  logic             run;
  logic             tick_now, fall_now, sample_now;
  logic [BRP_W-1:0] brp_cur;

  assign run     = !cfg_hold;
  assign brp_cur = cfg_q.brp_m1;

  // timing word is only taken while held idle
  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= '0;
    else if (cfg_hold) cfg_q <= unpack_cfg(cfg_word);
  end

  can_bt_prescaler #(.W(BRP_W)) u_presc (
    .clk(clk), .rst(rst), .run(run), .brp_m1(brp_cur),
    .tick_now(tick_now), .tick_q(tq_tick)
  );

  can_bt_edge u_edge (
    .clk(clk), .rst(rst), .run(run), .tick(tick_now),
    .rx(rx_in), .fall_now(fall_now)
  );

  can_bt_seq #(.P1_W(TS1_W), .P2_W(TS2_W), .J_W(SJW_W), .CW(QCNT_W)) u_seq (
    .clk(clk), .rst(rst), .run(run), .tick(tick_now), .fall(fall_now),
    .hs_en(hs_en), .ph1_m1(cfg_q.ph1_m1), .ph2_m1(cfg_q.ph2_m1),
    .sjw_m1(cfg_q.sjw_m1), .sample_now(sample_now),
    .sample_q(sample_strb), .tx_q(tx_strb)
  );

  can_bt_sampler #(.WIN(VOTE_WIN)) u_samp (
    .clk(clk), .rst(rst), .run(run), .tick(tick_now),
    .sample_now(sample_now), .rx(rx_in), .triple(cfg_q.triple),
    .bit_q(rx_bit)
  );
endmodule

// File: rtl/can_bittime_chk.sv
module can_bittime_chk #(
  parameter int unsigned BW = can_bt_pkg::BRP_W
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_hold,
  input logic [BW-1:0] brp_m1,
  input logic          tq_tick,
  input logic          sample_strb,
  input logic          tx_strb,
  input logic          rx_bit
);
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tq_tick && brp_m1 != '0) |=> !tq_tick); // R1

  AST_SAMPLE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    sample_strb |-> tq_tick); // R2

  AST_TX_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    tx_strb |-> tq_tick); // R2

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    !(sample_strb && tx_strb)); // R2

  AST_BIT_HELD: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_bit) |-> (sample_strb || $past(cfg_hold))); // R3

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_hold |=> (!tq_tick && !sample_strb && !tx_strb && rx_bit)); // R9
endmodule

bind can_bittime_gen can_bittime_chk #(.BW(can_bt_pkg::BRP_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_hold(cfg_hold), .brp_m1(brp_cur),
  .tq_tick(tq_tick), .sample_strb(sample_strb), .tx_strb(tx_strb),
  .rx_bit(rx_bit)
);

// File: tb/can_bittime_gen_tb_top.sv
module can_bittime_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_hold = 1'b1;
  logic [23:0] cfg_word = '0;
  logic        hs_en = 1'b0;
  logic        rx_in = 1'b1;
  logic        tq_tick, sample_strb, tx_strb, rx_bit;

  int n_chk = 0;
  int n_err = 0;
  int ntick;
  int ns, nt;
  int smp[4];
  int txs[4];
  logic rxb[4];

  always #10 clk = ~clk;

  can_bittime_gen dut_i (
    .clk(clk), .rst(rst), .cfg_hold(cfg_hold), .cfg_word(cfg_word),
    .hs_en(hs_en), .rx_in(rx_in), .tq_tick(tq_tick),
    .sample_strb(sample_strb), .tx_strb(tx_strb), .rx_bit(rx_bit)
  );

  function automatic logic [23:0] mk(int brp, int sjw, int t1, int t2, bit tri3);
    logic [23:0] w;
    w = '0;
    w[9:0]   = 10'(brp - 1);
    w[15:14] = 2'(sjw - 1);
    w[19:16] = 4'(t1 - 1);
    w[22:20] = 3'(t2 - 1);
    w[23]    = tri3;
    return w;
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic start(logic [23:0] w, logic hs, logic rx0);
    @(negedge clk);
    cfg_hold = 1'b1;
    cfg_word = w;
    hs_en    = hs;
    rx_in    = rx0;
    repeat (2) @(negedge clk);
    cfg_hold = 1'b0;
    ntick = 0; ns = 0; nt = 0;
    for (int i = 0; i < 4; i++) begin smp[i] = -1; txs[i] = -1; rxb[i] = 1'b1; end
  endtask

  task automatic step();
    do @(negedge clk); while (tq_tick !== 1'b1);
    ntick++;
    if (sample_strb) begin
      if (ns < 4) begin smp[ns] = ntick; rxb[ns] = rx_bit; end
      ns++;
    end
    if (tx_strb) begin
      if (nt < 4) txs[nt] = ntick;
      nt++;
    end
  endtask

  task automatic run_to(int k);
    while (ntick < k) step();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 reset tq_tick", int'(tq_tick), 0);
    chk("R9 reset rx_bit", int'(rx_bit), 1);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 hold strobes", int'(tq_tick | sample_strb | tx_strb), 0);
    chk("R9 hold rx_bit", int'(rx_bit), 1);
  endtask

  task automatic t_prescale(int p);
    int cyc;
    start(mk(p, 2, 5, 3, 1'b0), 1'b0, 1'b1);
    step();
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (tq_tick !== 1'b1);
    chk($sformatf("R1 tick spacing P=%0d", p), cyc, p);
  endtask

  task automatic t_nominal();
    start(mk(2, 2, 5, 3, 1'b0), 1'b0, 1'b1);
    run_to(18);
    chk("R2 first sample", smp[0], 6);
    chk("R2 first tx", txs[0], 9);
    chk("R2 second sample", smp[1], 15);
    chk("R2 second tx", txs[1], 18);
    chk("R3 recessive sample", int'(rxb[0]), 1);
  endtask

  task automatic t_lengthen(int sjw, int edge_at, int exp_s, int exp_t);
    start(mk(2, sjw, 5, 3, 1'b0), 1'b0, 1'b1);
    run_to(edge_at - 1);
    rx_in = 1'b0;
    run_to(exp_t + 1);
    chk($sformatf("R5 sample J=%0d edge=%0d", sjw, edge_at), smp[0], exp_s);
    chk($sformatf("R5 tx J=%0d edge=%0d", sjw, edge_at), txs[0], exp_t);
  endtask

  task automatic t_shorten(int sjw, int exp_t, int exp_s2);
    start(mk(2, sjw, 5, 3, 1'b0), 1'b0, 1'b1);
    run_to(6);
    rx_in = 1'b0;
    run_to(exp_s2 + 1);
    chk($sformatf("R6 tx J=%0d", sjw), txs[0], exp_t);
    chk($sformatf("R6 next sample J=%0d", sjw), smp[1], exp_s2);
  endtask

  task automatic t_once();
    start(mk(2, 2, 5, 3, 1'b0), 1'b0, 1'b0);
    run_to(10);
    chk("R7 sync-quantum edge ignored", smp[0], 6);
    start(mk(2, 2, 5, 3, 1'b0), 1'b0, 1'b1);
    run_to(1); rx_in = 1'b0;
    run_to(2); rx_in = 1'b1;
    run_to(3); rx_in = 1'b0;
    run_to(10);
    chk("R7 second edge ignored", smp[0], 7);
    chk("R7 tx after one resync", txs[0], 10);
  endtask

  task automatic t_hard();
    start(mk(2, 2, 5, 3, 1'b0), 1'b1, 1'b1);
    run_to(3);
    rx_in = 1'b0;
    run_to(13);
    chk("R8 hard sync in phase 1 sample", smp[0], 9);
    chk("R8 hard sync in phase 1 tx", txs[0], 12);
    start(mk(2, 2, 5, 3, 1'b0), 1'b1, 1'b1);
    run_to(7);
    rx_in = 1'b0;
    run_to(17);
    chk("R8 sample before hard sync", smp[0], 6);
    chk("R8 sample after hard sync", smp[1], 13);
    chk("R8 no tx for cut bit", txs[0], 16);
  endtask

  task automatic t_sampling();
    // single sample, bus dominant until the sample quantum, recessive at it
    start(mk(2, 2, 5, 3, 1'b0), 1'b0, 1'b0);
    run_to(5); rx_in = 1'b1;
    run_to(7);
    chk("R3 single sample value", int'(rxb[0]), 1);
    start(mk(2, 2, 5, 3, 1'b0), 1'b0, 1'b0);
    run_to(7);
    chk("R3 dominant sample value", int'(rxb[0]), 0);
    // triple: samples 0,0,1 -> 0
    start(mk(2, 2, 5, 3, 1'b1), 1'b0, 1'b0);
    run_to(5); rx_in = 1'b1;
    run_to(7);
    chk("R4 majority 0,0,1", int'(rxb[0]), 0);
    // triple: samples 0,1,1 -> 1
    start(mk(2, 2, 5, 3, 1'b1), 1'b0, 1'b0);
    run_to(4); rx_in = 1'b1;
    run_to(7);
    chk("R4 majority 0,1,1", int'(rxb[0]), 1);
  endtask

  task automatic t_cfg_ignore();
    start(mk(2, 2, 5, 3, 1'b0), 1'b0, 1'b1);
    run_to(2);
    cfg_word = mk(2, 2, 8, 3, 1'b0);
    run_to(10);
    chk("R9 running change ignored", smp[0], 6);
    start(mk(2, 2, 8, 3, 1'b0), 1'b0, 1'b1);
    run_to(10);
    chk("R9 new word taken in hold", smp[0], 9);
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_prescale(3);
    t_prescale(1);
    t_prescale(64);
    t_nominal();
    t_lengthen(2, 3, 8, 11);
    t_lengthen(2, 5, 8, 11);
    t_lengthen(4, 5, 10, 13);
    t_shorten(2, 7, 13);
    t_shorten(1, 8, 14);
    t_once();
    t_hard();
    t_sampling();
    t_cfg_ignore();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule